// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Transmitter

This block turns a stream of packed two-channel PCM words into a single biphase-mark coded line, in the format of IEC 60958 consumer and professional digital audio links. Each 32-bit input word describes one subframe. The word holds a left-justified audio sample, the validity, user-data and channel-status bits, and a 4-bit code that picks the preamble. The block sends an 8-cell preamble and then 28 coded data slots. It computes the last of these slots, the parity slot, itself.

The block runs on a fast audio clock. A one-cycle enable marks every half-bit cell, so the enable rate is twice the line bit rate, and one subframe lasts 64 enables. Input arrives over a valid/ready stream that feeds a one-entry holding register. `s_ready` is high exactly when that register is empty. A word is taken on any clock edge where `s_valid` and `s_ready` are both high. The producer must keep `s_valid` and `s_data` steady while `s_ready` is low. The held word is used at the next subframe boundary, which empties the register again.

If the register is empty at a boundary, the block sends a null subframe marked invalid and pulses `underrun`. While it sends nulls, the block keeps the A/B channel order and the 192-frame block structure going by itself.

Top module: `bmc_frame_tx`

## Requirements
- R1: Data slot k (k = 4..30) carries input bit k, so the sample in bits 27:4 is sent LSB first from slot 4 and its MSB in slot 27. Bit 28 is validity (slot 28), bit 29 user data (slot 29) and bit 30 channel status (slot 30).
- R2: Slot 31 carries a parity bit that the block computes, so that slots 4..31 hold an even number of ones. Input bit 31 has no effect on the line. Because parity is even, the line is low at every subframe boundary.
- R3: Preamble code 4'b0001 (start of block plus channel A) sends the cells 11101000. Code 4'b0010 (channel A) sends 11100010. Code 4'b0011 (channel B) sends 11100100. Cells are sent left to right and apply when the line was low before the preamble; the complement applies when it was high.
- R4: In each data slot the line inverts at the start of the slot, and inverts again at mid-slot when the slot's bit is 1.
- R5: `s_ready` is high exactly when the holding register is empty. An accepted word drops `s_ready` on the next cycle, and the word is sent in the next subframe that starts after it was accepted.
- R6: When no word is held at a subframe boundary, the block sends a null subframe: sample 0, validity 1, user 0, channel status 0, parity 1. It also raises `underrun` for exactly one clock cycle, on the cycle after the enable that starts that subframe.
- R7: A null subframe, or a word with an unknown code, takes the channel opposite to that of the previous subframe, with channel B sent as 11100100. The first subframe after reset is channel A.
- R8: For a self-selected channel-A subframe, the block sends the start-of-block preamble when 192 frames have begun since the last start-of-block preamble (and for the first one after reset). Otherwise it sends the channel-A preamble.
- R9: A word whose code is not 1, 2 or 3 is still sent with its own data bits, but the block picks its preamble as in R7 and R8.
- R10: During reset `line_out` is low, `s_ready` is high and `underrun` is low. `line_out` changes only on cycles where `half_bit_en` is high. The first enable after reset starts the first subframe, and each subframe lasts 64 enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_bit_en | input | 1 | One-cycle pulse per half-bit cell |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Holding register empty, word can be taken |
| s_data | input | 32 | Packed subframe word |
| line_out | output | 1 | Biphase-mark coded line |
| underrun | output | 1 | One-cycle pulse for each inserted null subframe |

## Verification
The bound checker counts enables on its own and checks several rules on every cycle. It checks that the line stays still between enables and that it inverts at every data-slot start. It checks the fixed opening cells shared by all three preambles, and that the line is low at every boundary, which follows from even parity. It also checks that an accepted word closes `s_ready` and that an underrun pulse is a single cycle that follows an empty holding register.

Some behaviour only the bench scenarios can show, by decoding whole subframes against a model built from the requirements. This covers which preamble each code selects and the order of the sample bits. It covers the replacement of the input parity bit, the contents of the null subframes, and the channel choice for unknown codes. It also covers the start-of-block preamble forced after 192 self-generated frames.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

  localparam int SLOTS      = 32;
  localparam int PRE_SLOTS  = 4;
  localparam int PRE_CELLS  = 2 * PRE_SLOTS;
  localparam int CODE_W     = 4;
  localparam int WORD_W     = SLOTS;
  localparam int PAYLOAD_W  = SLOTS - PRE_SLOTS;
  localparam int VALID_SLOT = 28;

  localparam logic [CODE_W-1:0] CODE_BLK = 4'h1;
  localparam logic [CODE_W-1:0] CODE_CHA = 4'h2;
  localparam logic [CODE_W-1:0] CODE_CHB = 4'h3;

  typedef enum logic [1:0] {
    PRE_BLK = 2'd0,
    PRE_CHA = 2'd1,
    PRE_CHB = 2'd2
  } pre_e;

  // Cell pattern for a low line before the preamble, first cell in the MSB.
  function automatic logic [PRE_CELLS-1:0] pre_pattern(pre_e p);
    case (p)
      PRE_BLK: return 8'b1110_1000;
      PRE_CHA: return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction

endpackage

// File: rtl/bmc_tx_hold.sv
module bmc_tx_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign s_ready = !full_q;
  assign full    = full_q;
  assign data    = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (s_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= s_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bmc_tx_sequencer.sv
module bmc_tx_sequencer
  import bmc_tx_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boundary,
  input  logic                 have_word,
  input  logic [WORD_W-1:0]    word,
  output logic                 take,
  output pre_e                 ptype,
  output logic [PAYLOAD_W-1:0] payload,
  output logic                 underrun
);

  localparam int FCNT_W  = $clog2(FRAMES_PER_BLOCK);
  localparam int BODY_W  = PAYLOAD_W - 1;
  localparam int VAL_IDX = VALID_SLOT - PRE_SLOTS;
  localparam logic [FCNT_W-1:0] LAST_FRAME = FCNT_W'(FRAMES_PER_BLOCK - 1);

  logic              next_is_b;
  logic [FCNT_W-1:0] next_frame;
  logic [CODE_W-1:0] code;
  logic              code_ok;
  pre_e              auto_type;
  logic [BODY_W-1:0] body;
  logic [BODY_W-1:0] null_body;

  assign code    = word[CODE_W-1:0];
  assign code_ok = have_word &&
                   ((code == CODE_BLK) || (code == CODE_CHA) || (code == CODE_CHB));

  assign auto_type = next_is_b           ? PRE_CHB :
                     (next_frame == '0)  ? PRE_BLK : PRE_CHA;

  always_comb begin
    ptype = auto_type;
    if (code_ok) begin
      case (code)
        CODE_BLK: ptype = PRE_BLK;
        CODE_CHA: ptype = PRE_CHA;
        default:  ptype = PRE_CHB;
      endcase
    end
  end

  always_comb begin
    null_body          = '0;
    null_body[VAL_IDX] = 1'b1;
  end

  assign body    = have_word ? word[WORD_W-2:CODE_W] : null_body;
  assign payload = {^body, body};
  assign take    = boundary && have_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_is_b  <= 1'b0;
      next_frame <= '0;
      underrun   <= 1'b0;
    end else begin
      underrun <= boundary && !have_word;
      if (boundary) begin
        if (ptype == PRE_CHB) begin
          next_is_b <= 1'b0;
        end else begin
          next_is_b <= 1'b1;
          if (ptype == PRE_BLK)
            next_frame <= FCNT_W'(1);
          else if (next_frame == LAST_FRAME)
            next_frame <= '0;
          else
            next_frame <= next_frame + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bmc_tx_encoder.sv
module bmc_tx_encoder
  import bmc_tx_pkg::*;
#(
  parameter int NSLOTS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       half_bit_en,
  input  pre_e                       ptype,
  input  logic [NSLOTS-PRE_SLOTS-1:0] payload,
  output logic                       boundary,
  output logic                       line_out
);

  localparam int CELLS  = 2 * NSLOTS;
  localparam int CELL_W = $clog2(CELLS);
  localparam int DATA_W = NSLOTS - PRE_SLOTS;
  localparam int PIDX_W = $clog2(PRE_CELLS);
  localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(CELLS - 1);

  logic [CELL_W-1:0]    cell_q, cell_nxt;
  logic                 line_q, ref_q, line_nxt;
  logic [PRE_CELLS-1:0] pat_q, pat_new;
  logic [DATA_W-1:0]    bits_q;
  logic [CELL_W-2:0]    didx;
  logic [PIDX_W-1:0]    pidx;

  assign boundary = half_bit_en && (cell_q == LAST_CELL);
  assign cell_nxt = boundary ? '0 : cell_q + 1'b1;
  assign pat_new  = pre_pattern(ptype);
  assign pidx     = PIDX_W'(PRE_CELLS - 1) - cell_nxt[PIDX_W-1:0];
  assign didx     = cell_nxt[CELL_W-1:1] - (CELL_W-1)'(PRE_SLOTS);

  always_comb begin
    if (boundary)
      line_nxt = pat_new[PRE_CELLS-1] ^ line_q;
    else if (cell_nxt < CELL_W'(PRE_CELLS))
      line_nxt = pat_q[pidx] ^ ref_q;
    else if (!cell_nxt[0])
      line_nxt = ~line_q;
    else
      line_nxt = line_q ^ bits_q[didx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_q <= LAST_CELL;
      line_q <= 1'b0;
      ref_q  <= 1'b0;
      pat_q  <= '0;
      bits_q <= '0;
    end else if (half_bit_en) begin
      cell_q <= cell_nxt;
      line_q <= line_nxt;
      if (boundary) begin
        ref_q  <= line_q;
        pat_q  <= pat_new;
        bits_q <= payload;
      end
    end
  end

  assign line_out = line_q;

endmodule

// File: rtl/bmc_frame_tx.sv
module bmc_frame_tx
  import bmc_tx_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_bit_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              line_out,
  output logic              underrun
);

  logic                 have_word;
  logic [WORD_W-1:0]    held_word;
  logic                 take;
  logic                 boundary;
  pre_e                 ptype;
  logic [PAYLOAD_W-1:0] payload;

  bmc_tx_hold #(.W(WORD_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .take    (take),
    .full    (have_word),
    .data    (held_word)
  );

  bmc_tx_sequencer #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .have_word (have_word),
    .word      (held_word),
    .take      (take),
    .ptype     (ptype),
    .payload   (payload),
    .underrun  (underrun)
  );

  bmc_tx_encoder #(.NSLOTS(SLOTS)) i_enc (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_bit_en (half_bit_en),
    .ptype       (ptype),
    .payload     (payload),
    .boundary    (boundary),
    .line_out    (line_out)
  );

endmodule

// File: rtl/bmc_frame_tx_chk.sv
module bmc_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic half_bit_en,
  input logic s_valid,
  input logic s_ready,
  input logic line_out,
  input logic underrun
);

  // Independent count of enables: value = cell index of the next enable.
  logic [5:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (half_bit_en) cnt <= cnt + 1'b1;
  end

  p_line_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !half_bit_en |=> $stable(line_out));

  p_slot_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_bit_en && cnt >= 6'd8 && !cnt[0]) |=> (line_out != $past(line_out)));

  p_pre_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_bit_en && cnt == 6'd0) |=> (line_out != $past(line_out)));

  p_pre_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_bit_en && (cnt == 6'd1 || cnt == 6'd2)) |=> $stable(line_out));

  p_low_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_bit_en && cnt == 6'd0) |-> !line_out);

  p_accept_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_underrun_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  p_underrun_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ($past(s_ready) && $past(half_bit_en)));

endmodule

bind bmc_frame_tx bmc_frame_tx_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .half_bit_en (half_bit_en),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .line_out    (line_out),
  .underrun    (underrun)
);

// File: tb/test_bmc_frame_tx.sv
module test_bmc_frame_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  wire         s_ready, line_out, underrun;

  always #5 clk = ~clk;

  bmc_frame_tx i_bmc_frame_tx (
    .clk(clk), .rst_n(rst_n), .half_bit_en(en), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .line_out(line_out), .underrun(underrun)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int          pt;       // 0 block start, 1 channel A, 2 channel B
    logic [31:0] slots;
    bit          is_null;
    string       req;
  } exp_t;
  exp_t expq[$];

  int unsigned en_cnt = 0;
  logic        en_seen = 1'b0;
  int          sf_done = 0;
  int          next_exp = 0;

  // Bench model of self-selected sequencing (R7, R8)
  bit m_next_b = 0;
  int m_nf = 0;

  initial forever begin
    @(posedge clk);
    en <= rst_n ? ~en : 1'b0;
    en_seen <= en;
    if (en) en_cnt <= en_cnt + 1;
  end

  function automatic logic [7:0] pat(int pt);
    case (pt)
      0: return 8'b1110_1000;
      1: return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction

  function automatic logic [63:0] build(int pt, logic [31:0] sl, logic prev);
    logic [63:0] c;
    logic [7:0]  p;
    logic        lv;
    c = '0;
    p = pat(pt);
    for (int i = 0; i < 8; i++) c[i] = p[7-i] ^ prev;
    lv = c[7];
    for (int s = 4; s < 32; s++) begin
      lv = ~lv; c[2*s] = lv;
      lv = lv ^ sl[s]; c[2*s+1] = lv;
    end
    return c;
  endfunction

  function int boundaries();
    return (en_cnt == 0) ? 0 : int'((en_cnt - 1) / 64) + 1;
  endfunction

  task automatic push_exp(bit is_null, logic [31:0] w, string req);
    exp_t e;
    int   code;
    code = int'(w[3:0]);
    if (!is_null && code >= 1 && code <= 3) e.pt = code - 1;
    else e.pt = m_next_b ? 2 : ((m_nf == 0) ? 0 : 1);
    if (e.pt == 2) m_next_b = 0;
    else begin
      m_next_b = 1;
      m_nf = (e.pt == 0) ? 1 : ((m_nf == 191) ? 0 : m_nf + 1);
    end
    if (is_null) begin
      e.slots = 32'h0;
      e.slots[28] = 1'b1;
      e.slots[31] = 1'b1;
    end else begin
      e.slots = w;
      e.slots[3:0] = 4'h0;
      e.slots[31] = ^w[30:4];
    end
    e.is_null = is_null;
    e.req = req;
    expq.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic send(logic [31:0] w, string req);
    int tgt;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1;
    s_data  = w;
    @(negedge clk);
    s_valid = 1'b0;
    tgt = boundaries();
    while (next_exp < tgt) begin
      push_exp(1, 32'h0, "R6");
      next_exp++;
    end
    push_exp(0, w, req);
    next_exp = tgt + 1;
    check(s_ready == 1'b0, "R5", "ready after accept", int'(s_ready), 0);
  endtask

  task automatic skip(int k, string req);
    for (int i = 0; i < k; i++) begin
      push_exp(1, 32'h0, req);
      next_exp++;
    end
    while (boundaries() < next_exp) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Monitor: collects 64 cells per subframe and compares with the queue.
  initial begin : monitor
    logic [63:0] rx;
    logic [63:0] ex;
    logic        prev;
    int          ci;
    int          ur;
    exp_t        e;
    rx = '0; prev = 1'b0; ci = 0; ur = 0;
    forever begin
      @(negedge clk);
      if (rst_n && en_seen) begin
        if (ci == 0) ur = 0;
        if (underrun) ur++;
        rx[ci] = line_out;
        ci++;
        if (ci == 64) begin
          ci = 0;
          if (expq.size() == 0) begin
            check(1'b0, "R6", "unexpected subframe", sf_done, -1);
          end else begin
            e = expq.pop_front();
            ex = build(e.pt, e.slots, prev);
            checks++;
            if (rx !== ex) begin
              fails++;
              $display("FAIL %s subframe %0d: actual %h expected %h",
                       e.req, sf_done, rx, ex);
            end
            check(ur == (e.is_null ? 1 : 0), "R6", "underrun pulses",
                  ur, e.is_null ? 1 : 0);
          end
          prev = rx[63];
          sf_done++;
        end
      end else if (rst_n && underrun) begin
        ur++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    check(line_out == 1'b0, "R10", "line in reset", int'(line_out), 0);
    check(s_ready == 1'b1, "R10", "ready in reset", int'(s_ready), 1);
    check(underrun == 1'b0, "R10", "underrun in reset", int'(underrun), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_out == 1'b0, "R10", "line after reset", int'(line_out), 0);

    skip(1, "R7");
    send(32'h0ABC_DEF1, "R3");
    send(32'h8123_4563, "R2");
    send(32'h0BEE_F002, "R1");
    send(32'h7FFF_FFF3, "R4");
    send(32'h8000_0012, "R2");
    send(32'h4000_0103, "R1");
    skip(3, "R6");
    send(32'h0555_5550, "R9");
    send(32'h1AAA_AAAF, "R9");
    send(32'h0123_0007, "R9");
    skip(2, "R7");
    skip(400, "R8");
    send(32'h0765_4322, "R3");
    send(32'h2FED_CBA3, "R3");
    send(32'h0000_0011, "R1");
    skip(2, "R7");

    while (sf_done < next_exp) @(negedge clk);
    check(expq.size() == 0, "R6", "leftover expectations", expq.size(), 0);
    report();
  end

endmodule